// File: doc/BRIEF.md
# Windowed Mean-Square / RMS Power Integrator

This block estimates the power of a signed sample stream. Each valid sample is turned into a magnitude and squared, and only the upper bits of the square are kept. These scaled squares are summed over a window of a programmed number of valid samples. When a window closes, the block hands a snapshot of the sum to a bit-serial integer square-root unit, or, in mean-square mode, formats the sum directly. It then writes the value into a 20-bit holding register with a one-cycle valid pulse.

Windows follow one another with no gap. The sample that closes a window belongs to that window, and the next valid sample opens the next one. The square root of the finished window is computed in the background while the new window integrates. A gain-control loop or a power meter would raise the enable once the period and mode are set, then collect one result per window.

Top module: `pwr_msq_integrator`

## Requirements
- R1: While reset is asserted, and after it is released with no window yet finished, `result_o` is 0 and `res_valid_o` is 0.
- R2: Each valid sample is reduced to its magnitude, and that magnitude saturates at 2047, so -2048 counts as 2047. The magnitude is squared into a 22-bit value and only its top 11 bits are accumulated (square >> 11, at most 2046).
- R3: A window consists of `period_i` valid samples. Counting begins with samples presented in the cycle after `en_i` is first seen high. `period_i` is read at that first cycle and again each time a window closes. Periods of at least 128 are supported.
- R4: The window sum is held in a 24-bit accumulator that saturates at 16777215 and does not wrap.
- R5: With `mode_i` = 0 (rms), the result is floor(sqrt(sum)) zero-extended to 20 bits.
- R6: With `mode_i` = 1 (ms), the result is the upper 20 bits of the 24-bit sum (sum >> 4). The mode is captured when the window closes.
- R7: The next window starts with the very next valid sample after the closing one. No sample is lost while a square root is in progress, so every window with continuous input yields its own correct result.
- R8: `res_valid_o` is a one-cycle pulse, issued once per finished window, in the order the windows closed. `result_o` holds its value until the next pulse.
- R9: While `en_i` is low, no result is produced and the window in progress is discarded together with any pending root. A later enable starts a fresh window from zero.
- R10: The square-root unit is never started while it is still busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Measurement enable |
| mode_i | input | 1 | 0 = rms result, 1 = mean-square result |
| period_i | input | 24 | Window length in valid samples |
| in_valid_i | input | 1 | Sample qualifier |
| in_sample_i | input | 12 | Signed two's-complement sample |
| result_o | output | 20 | Holding register with the last result |
| res_valid_o | output | 1 | One-cycle pulse when `result_o` is written |

## Verification
On every cycle the assertions check four things. The valid output is a single-cycle pulse and stays quiet while the block is disabled. The root unit is never restarted mid-computation. The accumulator only falls at a window boundary, and an rms result never uses more than 12 bits. The numeric content of the results can only be shown by the bench's scenarios: the scaled squares, the saturating sum, the exact integer root, the mean-square truncation, back-to-back windows while the root runs, and fresh restart after re-enable. The bench compares each of these against sums it computes itself.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  typedef enum logic {
    MODE_RMS = 1'b0,
    MODE_MS  = 1'b1
  } pwr_mode_e;
endpackage

// File: rtl/pwr_sq_scale.sv
module pwr_sq_scale #(
  parameter int SAMPLE_W = 12,
  parameter int KEEP_W   = 11
) (
  input  logic signed [SAMPLE_W-1:0] sample_i,
  output logic        [KEEP_W-1:0]   sq_o
);
  localparam int MAG_W = SAMPLE_W - 1;
  localparam int SQ_W  = 2 * MAG_W;

  logic [SAMPLE_W-1:0] abs_v;
  logic [MAG_W-1:0]    mag;
  logic [SQ_W-1:0]     sq_full;

  always_comb begin
    abs_v = sample_i[SAMPLE_W-1] ? (~sample_i + 1'b1) : sample_i;
    // the most negative code folds onto the largest positive magnitude
    mag = abs_v[SAMPLE_W-1] ? {MAG_W{1'b1}} : abs_v[MAG_W-1:0];
    sq_full = SQ_W'(mag) * SQ_W'(mag);
    sq_o = sq_full[SQ_W-1 -: KEEP_W];
  end
endmodule

// File: rtl/pwr_window_acc.sv
module pwr_window_acc #(
  parameter int KEEP_W = 11,
  parameter int ACC_W  = 24,
  parameter int PER_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              mode_i,
  input  logic [PER_W-1:0]  period_i,
  input  logic              in_valid_i,
  input  logic [KEEP_W-1:0] sq_i,
  output logic [ACC_W-1:0]  acc_o,
  output logic [ACC_W-1:0]  snap_o,
  output logic              snap_mode_o,
  output logic              win_end_o
);
  logic              active_q, active_d;
  logic [PER_W-1:0]  timer_q, timer_d;
  logic [ACC_W-1:0]  acc_q, acc_d;
  logic [ACC_W-1:0]  snap_q, snap_d;
  logic              smode_q, smode_d;
  logic              wend_q, wend_d;
  logic [ACC_W:0]    sum_ext;
  logic [ACC_W-1:0]  sum_sat;

  always_comb begin
    sum_ext = {1'b0, acc_q} + (ACC_W+1)'(sq_i);
    sum_sat = sum_ext[ACC_W] ? {ACC_W{1'b1}} : sum_ext[ACC_W-1:0];

    active_d = active_q;
    timer_d  = timer_q;
    acc_d    = acc_q;
    snap_d   = snap_q;
    smode_d  = smode_q;
    wend_d   = 1'b0;

    if (!en_i) begin
      active_d = 1'b0;
      timer_d  = '0;
      acc_d    = '0;
    end else if (!active_q) begin
      active_d = 1'b1;
      timer_d  = period_i;
      acc_d    = '0;
    end else if (in_valid_i) begin
      if (timer_q == PER_W'(1)) begin
        snap_d  = sum_sat;
        smode_d = mode_i;
        wend_d  = 1'b1;
        acc_d   = '0;
        timer_d = period_i;
      end else begin
        acc_d   = sum_sat;
        timer_d = timer_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      timer_q  <= '0;
      acc_q    <= '0;
      snap_q   <= '0;
      smode_q  <= 1'b0;
      wend_q   <= 1'b0;
    end else begin
      active_q <= active_d;
      timer_q  <= timer_d;
      acc_q    <= acc_d;
      snap_q   <= snap_d;
      smode_q  <= smode_d;
      wend_q   <= wend_d;
    end
  end

  assign acc_o       = acc_q;
  assign snap_o      = snap_q;
  assign snap_mode_o = smode_q;
  assign win_end_o   = wend_q;
endmodule

// File: rtl/pwr_isqrt.sv
module pwr_isqrt #(
  parameter int RAD_W = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear_i,
  input  logic                 start_i,
  input  logic [RAD_W-1:0]     rad_i,
  output logic [RAD_W/2-1:0]   root_o,
  output logic                 busy_o,
  output logic                 done_o
);
  localparam int ROOT_W = RAD_W / 2;
  localparam int REM_W  = ROOT_W + 3;
  localparam int CNT_W  = $clog2(ROOT_W + 1);

  logic [RAD_W-1:0]  rad_q, rad_d;
  logic [REM_W-1:0]  rem_q, rem_d;
  logic [ROOT_W-1:0] root_q, root_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              busy_q, busy_d;
  logic              done_q, done_d;
  logic [REM_W-1:0]  rem_sh, trial;

  always_comb begin
    rem_sh = {rem_q[REM_W-3:0], rad_q[RAD_W-1 -: 2]};
    trial  = {1'b0, root_q, 2'b01};

    rad_d  = rad_q;
    rem_d  = rem_q;
    root_d = root_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    done_d = 1'b0;

    if (clear_i) begin
      busy_d = 1'b0;
      cnt_d  = '0;
    end else if (start_i) begin
      rad_d  = rad_i;
      rem_d  = '0;
      root_d = '0;
      cnt_d  = CNT_W'(ROOT_W);
      busy_d = 1'b1;
    end else if (busy_q) begin
      rad_d = {rad_q[RAD_W-3:0], 2'b00};
      if (rem_sh >= trial) begin
        rem_d  = rem_sh - trial;
        root_d = {root_q[ROOT_W-2:0], 1'b1};
      end else begin
        rem_d  = rem_sh;
        root_d = {root_q[ROOT_W-2:0], 1'b0};
      end
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rad_q  <= '0;
      rem_q  <= '0;
      root_q <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      rad_q  <= rad_d;
      rem_q  <= rem_d;
      root_q <= root_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  assign root_o = root_q;
  assign busy_o = busy_q;
  assign done_o = done_q;
endmodule

// File: rtl/pwr_msq_integrator.sv
module pwr_msq_integrator
  import pwr_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int KEEP_W   = 11,
  parameter int ACC_W    = 24,
  parameter int PER_W    = 24,
  parameter int RES_W    = 20
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       en_i,
  input  logic                       mode_i,
  input  logic [PER_W-1:0]           period_i,
  input  logic                       in_valid_i,
  input  logic signed [SAMPLE_W-1:0] in_sample_i,
  output logic [RES_W-1:0]           result_o,
  output logic                       res_valid_o
);
  localparam int ROOT_W = ACC_W / 2;

  logic             rst_meta_q, rst_sync_q;
  logic [KEEP_W-1:0] sq;
  logic [ACC_W-1:0] acc_mon, snap;
  logic             snap_mode, win_end;
  logic [ROOT_W-1:0] root;
  logic             root_busy, root_done, root_start;
  logic [RES_W-1:0] ms_fmt, rms_fmt;
  logic [RES_W-1:0] res_q, res_d;
  logic             rv_q, rv_d;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  pwr_sq_scale #(.SAMPLE_W(SAMPLE_W), .KEEP_W(KEEP_W)) u_sq (
    .sample_i (in_sample_i),
    .sq_o     (sq)
  );

  pwr_window_acc #(.KEEP_W(KEEP_W), .ACC_W(ACC_W), .PER_W(PER_W)) u_acc (
    .clk         (clk),
    .rst_n       (rst_sync_q),
    .en_i        (en_i),
    .mode_i      (mode_i),
    .period_i    (period_i),
    .in_valid_i  (in_valid_i),
    .sq_i        (sq),
    .acc_o       (acc_mon),
    .snap_o      (snap),
    .snap_mode_o (snap_mode),
    .win_end_o   (win_end)
  );

  assign root_start = en_i && win_end && (pwr_mode_e'(snap_mode) == MODE_RMS);

  pwr_isqrt #(.RAD_W(ACC_W)) u_root (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .clear_i (!en_i),
    .start_i (root_start),
    .rad_i   (snap),
    .root_o  (root),
    .busy_o  (root_busy),
    .done_o  (root_done)
  );

  generate
    if (ACC_W > RES_W) begin : g_ms_trunc
      assign ms_fmt = snap[ACC_W-1 -: RES_W];
    end else begin : g_ms_ext
      assign ms_fmt = RES_W'(snap);
    end
    if (RES_W > ROOT_W) begin : g_rms_ext
      assign rms_fmt = RES_W'(root);
    end else begin : g_rms_trunc
      assign rms_fmt = root[ROOT_W-1 -: RES_W];
    end
  endgenerate

  always_comb begin
    res_d = res_q;
    rv_d  = 1'b0;
    if (en_i) begin
      if (win_end && (pwr_mode_e'(snap_mode) == MODE_MS)) begin
        res_d = ms_fmt;
        rv_d  = 1'b1;
      end else if (root_done) begin
        res_d = rms_fmt;
        rv_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      res_q <= '0;
      rv_q  <= 1'b0;
    end else begin
      res_q <= res_d;
      rv_q  <= rv_d;
    end
  end

  assign result_o    = res_q;
  assign res_valid_o = rv_q;
endmodule

// File: rtl/pwr_msq_checker.sv
module pwr_msq_checker #(
  parameter int ACC_W = 24,
  parameter int RES_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en_i,
  input logic             res_valid_o,
  input logic [RES_W-1:0] result_o,
  input logic [ACC_W-1:0] acc_mon,
  input logic             win_end,
  input logic             snap_mode,
  input logic             root_start,
  input logic             root_busy
);
  localparam int ROOT_W = ACC_W / 2;

  // R8
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o |=> !res_valid_o);

  // R9
  quiet_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !res_valid_o);

  // R10
  root_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    root_start |-> !root_busy);

  // R4
  acc_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_mon < $past(acc_mon)) |-> (win_end || !$past(en_i)));

  // R5
  rms_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && !snap_mode) |-> (result_o >> ROOT_W) == '0);
endmodule

bind pwr_msq_integrator pwr_msq_checker #(.ACC_W(ACC_W), .RES_W(RES_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .en_i        (en_i),
  .res_valid_o (res_valid_o),
  .result_o    (result_o),
  .acc_mon     (acc_mon),
  .win_end     (win_end),
  .snap_mode   (snap_mode),
  .root_start  (root_start),
  .root_busy   (root_busy)
);

// File: tb/test_pwr_msq_integrator.sv
`timescale 1ns/1ps
module test_pwr_msq_integrator;
  logic        clk;
  logic        rst_n;
  logic        en;
  logic        mode;
  logic [23:0] period;
  logic        vld;
  logic signed [11:0] smp;
  logic [19:0] result;
  logic        rvalid;

  int checks = 0;
  int fails  = 0;
  int wr = 0;
  int rd = 0;
  logic [19:0] exp_q [256];
  string       tag_q [256];
  int          cnt;
  int unsigned sum;
  string       cur_tag;
  int          pulses;

  pwr_msq_integrator i_pwr_msq_integrator (
    .clk(clk), .rst_n(rst_n), .en_i(en), .mode_i(mode), .period_i(period),
    .in_valid_i(vld), .in_sample_i(smp), .result_o(result), .res_valid_o(rvalid)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int unsigned scaled_sq(input logic signed [11:0] x);
    int m;
    m = (x < 0) ? -int'(x) : int'(x);
    if (m > 2047) m = 2047;
    return (m * m) >> 11;
  endfunction

  function automatic int unsigned isqrt(input int unsigned v);
    int unsigned r = 0;
    while ((r + 1) * (r + 1) <= v) r++;
    return r;
  endfunction

  task automatic check(input string req, input int unsigned act, input int unsigned exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // result monitor
  always @(negedge clk) begin
    if (rvalid) begin
      pulses++;
      if (rd < wr) begin
        check(tag_q[rd % 256], result, exp_q[rd % 256]);
        rd++;
      end else check("R8 unexpected result pulse", 1, 0);
    end
  end

  task automatic start(input logic m, input int p, input string t);
    mode = m; period = 24'(p); cur_tag = t;
    en = 1'b1; vld = 1'b0;
    cnt = 0; sum = 0;
    @(negedge clk);
  endtask

  task automatic stop();
    repeat (20) @(negedge clk);
    en = 1'b0; vld = 1'b0;
    @(negedge clk);
    check({cur_tag, " R8 all results delivered"}, rd, wr);
  endtask

  task automatic push_sample(input logic v, input logic signed [11:0] x);
    vld = v; smp = x;
    if (v) begin
      sum = sum + scaled_sq(x);
      if (sum > 32'd16777215) sum = 32'd16777215;
      cnt++;
      if (cnt == int'(period)) begin
        exp_q[wr % 256] = mode ? 20'(sum >> 4) : 20'(isqrt(sum));
        tag_q[wr % 256] = cur_tag;
        wr++;
        cnt = 0; sum = 0;
      end
    end
    @(negedge clk);
  endtask

  initial begin : wd
    #(4 * 190000);
    check("watchdog", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_2024));
    rst_n = 1'b0; en = 1'b0; mode = 1'b0; period = 24'd128; vld = 1'b0; smp = '0;
    pulses = 0;
    repeat (3) @(negedge clk);
    check("R1 reset result", result, 0);
    check("R1 reset valid", rvalid, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release result", result, 0);
    check("R1 after release valid", rvalid, 0);

    // random rms, continuous valid, back-to-back windows
    start(1'b0, 128, "R5 R7 rms random");
    for (int i = 0; i < 128 * 5; i++) push_sample(1'b1, 12'($urandom));
    stop();

    // random ms with gaps, period 200
    start(1'b1, 200, "R6 R3 ms gaps");
    for (int i = 0; i < 1000; i++) push_sample(($urandom % 10) < 7, 12'($urandom));
    stop();

    // rms with gaps and odd period
    start(1'b0, 131, "R3 R5 rms gaps");
    for (int i = 0; i < 700; i++) push_sample(($urandom % 4) != 0, 12'($urandom));
    stop();

    // most negative code
    start(1'b0, 128, "R2 neg full scale");
    for (int i = 0; i < 128; i++) push_sample(1'b1, -12'sd2048);
    check("R2 neg window sum", sum, 0);
    stop();
    check("R2 root of 128*2046", exp_q[(wr - 1) % 256], 511);

    // small magnitudes round away in scaling
    start(1'b1, 128, "R2 small values");
    for (int i = 0; i < 128; i++) push_sample(1'b1, 12'sd45);
    stop();
    check("R2 small ms value", exp_q[(wr - 1) % 256], 0);

    // saturation in both modes
    start(1'b1, 9000, "R4 ms saturate");
    for (int i = 0; i < 9000; i++) push_sample(1'b1, 12'sd2047);
    stop();
    check("R4 ms saturated expectation", exp_q[(wr - 1) % 256], 1048575);
    start(1'b0, 9000, "R4 rms saturate");
    for (int i = 0; i < 9000; i++) push_sample(1'b1, -12'sd2047);
    stop();
    check("R4 rms saturated expectation", exp_q[(wr - 1) % 256], 4095);

    // disabled: no pulses, and partial window discarded
    pulses = 0;
    en = 1'b0;
    for (int i = 0; i < 300; i++) begin vld = 1'b1; smp = 12'sd1500; @(negedge clk); end
    vld = 1'b0;
    check("R9 no result while disabled", pulses, 0);
    start(1'b1, 150, "R9 partial then restart");
    for (int i = 0; i < 100; i++) push_sample(1'b1, 12'sd2000);
    en = 1'b0; vld = 1'b0; cnt = 0; sum = 0;
    repeat (3) @(negedge clk);
    check("R9 discarded partial window", pulses, 0);
    start(1'b1, 150, "R9 fresh window");
    for (int i = 0; i < 150; i++) push_sample(1'b1, 12'($urandom));
    stop();

    // R8 pulse count for a known number of windows
    pulses = 0;
    start(1'b0, 128, "R8 count");
    for (int i = 0; i < 128 * 3; i++) push_sample(1'b1, 12'($urandom));
    stop();
    check("R8 one pulse per window", pulses, 3);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule